// File: doc/BRIEF.md
# Acquisition Live/Real Time Preset Timer

This block keeps the elapsed-time record of a pulse-height acquisition run. Two seconds counters run from a shared system clock. One counts real time, that is every second of the run. The other counts live time, that is only the seconds during which the event converter was free. A busy input is raised for the length of each event conversion. While it is high, the live-time sub-second accumulator is frozen, so the time spent busy never reaches the live count.

The host writes a 16-bit preset value and chooses whether it applies to the live count or to the real count. A run begins with a start pulse, which clears both counters and the stop flag. The run ends by itself once the chosen counter reaches the preset. A preset of zero lets the run continue until the host restarts it. The host reads either counter one byte at a time. When the low byte is read, the high byte is captured, so the two reads together give one coherent 16-bit value even while the counter is still moving.

Top module: `acqt_preset_timer`

## Requirements
- R1: After reset, `running`, `stop_flag` and `rd_data` are 0, and both seconds counters read as 0.
- R2: A `run_start` pulse clears both counters, both sub-second accumulators and `stop_flag`, and sets `running` at the same clock edge.
- R3: While `running` is 1, the real counter gains exactly one second for every TICK_DIV clock edges, whatever the level of `busy`.
- R4: The live accumulator advances only on clock edges where `running` is 1 and `busy` is 0. Its partial count is kept across busy intervals. One live second is credited each time TICK_DIV such edges have accumulated.
- R5: While `running` is 0, neither counter changes.
- R6: `preset_wr` loads `preset_val` together with the source bit `preset_live`, where 1 selects the live counter and 0 selects the real counter. If the preset is nonzero and the selected counter is at or above the preset, `stop_flag` rises and `running` falls on the next clock edge.
- R7: Once set, `stop_flag` stays at 1 until a `stop_clear` pulse or a `run_start` pulse.
- R8: With a preset of zero, the run never stops by itself.
- R9: A read request with `rd_hi`=0 returns bits 7:0 of the chosen counter on `rd_data` one clock after the request, where `rd_sel` 0 chooses real and 1 chooses live. The same request captures bits 15:8. A request with `rd_hi`=1 returns that captured byte, not the counter's current high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_start | input | 1 | Pulse: clear counters and begin a run |
| stop_clear | input | 1 | Pulse: clear the stop flag |
| busy | input | 1 | High while an event conversion is in progress (dead time) |
| preset_wr | input | 1 | Load preset value and source |
| preset_live | input | 1 | Preset source: 1 live, 0 real |
| preset_val | input | 16 | Preset in seconds; 0 disables the automatic stop |
| rd_req | input | 1 | Byte read request |
| rd_sel | input | 1 | Counter to read: 0 real, 1 live |
| rd_hi | input | 1 | 0 low byte (captures high), 1 captured high byte |
| rd_data | output | 8 | Registered read byte |
| running | output | 1 | Run in progress |
| stop_flag | output | 1 | Preset reached |

## Verification
A counter's new value becomes visible right after the TICK_DIV-th qualifying edge that follows the start edge. `stop_flag` follows one edge after that, because the compare looks at the registered counter. A read byte appears on `rd_data` one edge after its request, and it shows the counter as it stood just before that edge. The bench drives inputs one nanosecond after a rising edge and counts edges from the start edge exactly. At the last edge before a due result it checks that the output has not yet changed, and at the due edge it checks that it has. Busy intervals are placed so that the live second lands on a known edge, and split intervals show that the partial live count carries over.

// File: rtl/acqt_pkg.sv
package acqt_pkg;
   localparam int BYTE_W  = 8;
   localparam int CNT_W   = 2 * BYTE_W;
   localparam int NCHAN   = 2;
   localparam int CH_REAL = 0;
   localparam int CH_LIVE = 1;

   typedef enum logic {
      SRC_REAL = 1'b0,
      SRC_LIVE = 1'b1
   } src_e;
endpackage

// File: rtl/acqt_sec_counter.sv
module acqt_sec_counter #(
   parameter int unsigned TICK_DIV = 50_000_000,
   parameter int unsigned CNT_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   output logic [CNT_W-1:0] sec_q
);
   localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

   initial assert (TICK_DIV >= 2) else $error("TICK_DIV must be at least 2");
   initial assert (CNT_W >= 1) else $error("CNT_W must be positive");

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         sec_q <= '0;
      end else if (clr) begin
         pre_q <= '0;
         sec_q <= '0;
      end else if (en) begin
         if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            sec_q <= sec_q + 1'b1;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   // R5: a gated-off counter holds its value
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !clr |=> $stable(sec_q));

   // R3: never more than one second credited per edge
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (CNT_W'(sec_q - $past(sec_q)) <= CNT_W'(1)));
endmodule

// File: rtl/acqt_byte_reader.sv
module acqt_byte_reader
   import acqt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              sel,
   input  logic              hi,
   input  logic [CNT_W-1:0]  real_cnt,
   input  logic [CNT_W-1:0]  live_cnt,
   output logic [BYTE_W-1:0] rd_data
);
   logic [CNT_W-1:0]  pick;
   logic [BYTE_W-1:0] hi_latch_q;

   assign pick = sel ? live_cnt : real_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data    <= '0;
         hi_latch_q <= '0;
      end else if (req) begin
         if (hi) begin
            rd_data <= hi_latch_q;
         end else begin
            rd_data    <= pick[BYTE_W-1:0];
            hi_latch_q <= pick[CNT_W-1:BYTE_W];
         end
      end
   end

   // R9: output byte changes only in response to a request
   a_r9_rd_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> $stable(rd_data));
endmodule

// File: rtl/acqt_preset_timer.sv
module acqt_preset_timer
   import acqt_pkg::*;
#(
   parameter int unsigned TICK_DIV = 50_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_start,
   input  logic              stop_clear,
   input  logic              busy,
   input  logic              preset_wr,
   input  logic              preset_live,
   input  logic [CNT_W-1:0]  preset_val,
   input  logic              rd_req,
   input  logic              rd_sel,
   input  logic              rd_hi,
   output logic [BYTE_W-1:0] rd_data,
   output logic              running,
   output logic              stop_flag
);
   logic [NCHAN-1:0] chan_en;
   logic [CNT_W-1:0] sec_q [NCHAN];
   logic [CNT_W-1:0] preset_q;
   src_e             src_q;
   logic [CNT_W-1:0] cmp_cnt;
   logic             hit;

   assign chan_en[CH_REAL] = running;
   assign chan_en[CH_LIVE] = running & ~busy;

   for (genvar c = 0; c < NCHAN; c++) begin : g_ch
      acqt_sec_counter #(
         .TICK_DIV (TICK_DIV),
         .CNT_W    (CNT_W)
      ) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (run_start),
         .en    (chan_en[c]),
         .sec_q (sec_q[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preset_q <= '0;
         src_q    <= SRC_REAL;
      end else if (preset_wr) begin
         preset_q <= preset_val;
         src_q    <= src_e'(preset_live);
      end
   end

   assign cmp_cnt = (src_q == SRC_LIVE) ? sec_q[CH_LIVE] : sec_q[CH_REAL];
   assign hit     = (preset_q != '0) && (cmp_cnt >= preset_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         stop_flag <= 1'b0;
      end else if (run_start) begin
         running   <= 1'b1;
         stop_flag <= 1'b0;
      end else if (running && hit) begin
         running   <= 1'b0;
         stop_flag <= 1'b1;
      end else if (stop_clear) begin
         stop_flag <= 1'b0;
      end
   end

   acqt_byte_reader u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (rd_req),
      .sel      (rd_sel),
      .hi       (rd_hi),
      .real_cnt (sec_q[CH_REAL]),
      .live_cnt (sec_q[CH_LIVE]),
      .rd_data  (rd_data)
   );

   // R4: live time can never exceed real time
   a_r4_live_le_real: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q[CH_LIVE] <= sec_q[CH_REAL]);

   // R6: a stopped run is not running
   a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_flag |-> !running);

   // R6: stop only rises out of a running state
   a_r6_rise_from_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_flag) |-> $past(running));

   // R7: stop flag is sticky
   a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stop_flag && !stop_clear && !run_start |=> stop_flag);

   // R8: zero preset never ends a run
   a_r8_zero_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
      running && (preset_q == '0) |=> running);
endmodule

// File: tb/acqt_preset_timer_test.sv
`timescale 1ns/1ps
module acqt_preset_timer_test;
   localparam int unsigned TD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_start = 1'b0, stop_clear = 1'b0, busy = 1'b0;
   logic        preset_wr = 1'b0, preset_live = 1'b0;
   logic [15:0] preset_val = '0;
   logic        rd_req = 1'b0, rd_sel = 1'b0, rd_hi = 1'b0;
   logic [7:0]  rd_data;
   logic        running, stop_flag;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   acqt_preset_timer #(.TICK_DIV(TD)) uut (
      .clk(clk), .rst_n(rst_n), .run_start(run_start), .stop_clear(stop_clear),
      .busy(busy), .preset_wr(preset_wr), .preset_live(preset_live),
      .preset_val(preset_val), .rd_req(rd_req), .rd_sel(rd_sel), .rd_hi(rd_hi),
      .rd_data(rd_data), .running(running), .stop_flag(stop_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic start_run();
      @(posedge clk); #1 run_start = 1'b1;
      @(posedge clk); #1 run_start = 1'b0;
   endtask

   task automatic load_preset(input int val, input logic live);
      @(posedge clk); #1;
      preset_wr = 1'b1; preset_val = 16'(val); preset_live = live;
      @(posedge clk); #1 preset_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, input logic hi, output logic [7:0] v);
      rd_req = 1'b1; rd_sel = sel; rd_hi = hi;
      @(posedge clk); #1 rd_req = 1'b0;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 running", running, 0);
      chk("R1 stop_flag", stop_flag, 0);
      chk("R1 rd_data", rd_data, 0);
      rd(1'b0, 1'b0, v); chk("R1 real low", v, 0);
      rd(1'b1, 1'b0, v); chk("R1 live low", v, 0);
   endtask

   task automatic t_real_preset();
      logic [7:0] v;
      load_preset(3, 1'b0);
      busy = 1'b1;
      start_run();
      tick(12); busy = 1'b0;
      tick(18);
      chk("R6 real preset not yet", stop_flag, 0);
      chk("R3 still running", running, 1);
      tick(1);
      chk("R6 real preset stop", stop_flag, 1);
      chk("R6 running cleared", running, 0);
      rd(1'b0, 1'b0, v); chk("R3 real low", v, 3);
      rd(1'b0, 1'b1, v); chk("R9 real high", v, 0);
      rd(1'b1, 1'b0, v); chk("R4 live after busy", v, 1);
   endtask

   task automatic t_live_split();
      logic [7:0] v;
      load_preset(1, 1'b1);
      busy = 1'b0;
      start_run();
      tick(5); busy = 1'b1;
      tick(7); busy = 1'b0;
      tick(5);
      chk("R4 partial carried, not yet", stop_flag, 0);
      tick(1);
      chk("R4 split live stop", stop_flag, 1);
      rd(1'b1, 1'b0, v); chk("R4 live split", v, 1);
      rd(1'b0, 1'b0, v); chk("R3 real split", v, 1);
   endtask

   task automatic t_live_preset_hold();
      logic [7:0] v;
      load_preset(2, 1'b1);
      busy = 1'b1;
      start_run();
      tick(15); busy = 1'b0;
      tick(20);
      chk("R6 live preset not yet", stop_flag, 0);
      tick(1);
      chk("R6 live preset stop", stop_flag, 1);
      rd(1'b1, 1'b0, v); chk("R6 live value", v, 2);
      rd(1'b0, 1'b0, v); chk("R3 real with live preset", v, 3);
      tick(40);
      chk("R7 stop held", stop_flag, 1);
      rd(1'b0, 1'b0, v); chk("R5 real frozen", v, 3);
      rd(1'b1, 1'b0, v); chk("R5 live frozen", v, 2);
      stop_clear = 1'b1;
      @(posedge clk); #1 stop_clear = 1'b0;
      chk("R7 stop cleared", stop_flag, 0);
      chk("R7 still idle", running, 0);
      tick(20);
      rd(1'b0, 1'b0, v); chk("R5 frozen after clear", v, 3);
   endtask

   task automatic t_restart();
      logic [7:0] v;
      load_preset(1, 1'b0);
      start_run();
      tick(20);
      chk("R7 stop set before restart", stop_flag, 1);
      start_run();
      chk("R2 stop cleared by start", stop_flag, 0);
      chk("R2 running set", running, 1);
      rd(1'b0, 1'b0, v); chk("R2 real cleared", v, 0);
   endtask

   task automatic t_zero_preset();
      logic [7:0] v;
      load_preset(0, 1'b0);
      start_run();
      tick(124);
      rd(1'b0, 1'b0, v); chk("R8 real keeps counting", v, 12);
      chk("R8 running", running, 1);
      chk("R8 no stop", stop_flag, 0);
   endtask

   task automatic t_byte_latch();
      logic [7:0] v;
      load_preset(0, 1'b0);
      busy = 1'b0;
      start_run();
      tick(2559);
      rd(1'b0, 1'b0, v); chk("R9 low 255", v, 8'hFF);
      tick(100);
      rd(1'b0, 1'b1, v); chk("R9 high latched not live", v, 8'h00);
      rd(1'b0, 1'b0, v); chk("R9 low 266", v, 8'h0A);
      rd(1'b0, 1'b1, v); chk("R9 high after relatch", v, 8'h01);
      rd(1'b1, 1'b0, v); chk("R9 live select low", v, 8'h0A);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_real_preset();
      t_live_split();
      t_live_preset_hold();
      t_restart();
      t_zero_preset();
      t_byte_latch();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule